// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Port

This block is the slave end of an 8-bit shared address/data bus placed in front of a 128-byte space of control registers and RAM. A static strap input picks one of two bus styles. In the first, an active-high data strobe and a read/write level control each access. In the second, the bus uses separate active-low read and write strobes. In both styles an address strobe first loads a 7-bit address from the shared lines. The later strobe phase then reads or writes that location.

All bus inputs, including the shared lines, pass through one multi-flop synchronizer into the system clock domain. Edges are detected on the synchronized copies. A write leaves the block as a one-cycle pulse that carries address, data and a bit-enable mask. A read raises a request with the latched address, and the port drives the byte that the storage array returns combinationally. Chip select, a power-fail write-protect input and an access lockout input gate every access. Two whole-byte locations are read-only, and the top bit of two further locations is read-only.

Top module: `mbus_port`

## Requirements
- R1: The level of `bus_mode_i` selects the protocol. 1 selects strobe-plus-level timing, where `ds_i` is an active-high data strobe and `rw_i` is high for read and low for write. 0 selects separate strobes, where `ds_i` is an active-low read strobe and `rw_i` is an active-low write strobe.
- R2: A falling edge of `as_i` captures bits 6..0 of `ad_i` as the access address. Bit 7 takes no part in the address.
- R3: A rising edge of `as_i` clears the latched address and marks it invalid, whatever the level of `cs_ni`. No read or write takes place while no valid address is latched.
- R4: With `bus_mode_i`=1, `ad_oe_o` is high while `ds_i` is high and `rw_i` is high, and it drops after `ds_i` falls.
- R5: With `bus_mode_i`=1, a falling edge of `ds_i` while `rw_i` is low produces exactly one `wr_en_o` cycle. That cycle carries the latched address and the `ad_i` value present at the edge.
- R6: With `bus_mode_i`=0, `ad_oe_o` is high only while `ds_i` is low, and it drops after `ds_i` rises.
- R7: With `bus_mode_i`=0, the trailing (rising) edge of `rw_i` produces exactly one `wr_en_o` cycle. That cycle carries the latched address and the data present at that edge.
- R8: While `cs_ni` is high, no read drive and no write occur, but an address strobe still loads the address.
- R9: While `wp_i` is high, no read drive and no write occur, and the latched address and its valid state do not change.
- R10: While `lk_ni` is low, no read drive and no write occur.
- R11: Addresses 0x0C and 0x0D are read-only: a write to either produces no `wr_en_o`.
- R12: A write to address 0x00 or 0x0A has bit 7 of `wr_be_o` cleared (mask 0x7F). Every other write has mask 0xFF.
- R13: An input edge reaches the outputs after SYNC_STAGES+1 clock edges. `ad_o` equals `rd_data_i` and `rd_req_o` is high while `ad_oe_o` is high. `rd_addr_o` shows the latched address.
- R14: After reset, `ad_oe_o`, `rd_req_o` and `wr_en_o` are low and no address is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_mode_i | input | 1 | Protocol strap: 1 strobe+level, 0 separate strobes |
| as_i | input | 1 | Address strobe, active high |
| ds_i | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw_i | input | 1 | Read/write level (mode 1) or active-low write strobe (mode 0) |
| cs_ni | input | 1 | Chip select, active low |
| wp_i | input | 1 | Power-fail write protect, active high |
| lk_ni | input | 1 | Access lockout, active low |
| ad_i | input | 8 | Shared address/data lines, input side |
| ad_o | output | 8 | Shared data lines, output side |
| ad_oe_o | output | 1 | Tri-state enable for ad_o |
| rd_req_o | output | 1 | Read request to storage |
| rd_addr_o | output | 7 | Latched address |
| rd_data_i | input | 8 | Read data from storage (combinational) |
| wr_en_o | output | 1 | One-cycle write pulse |
| wr_addr_o | output | 7 | Write address |
| wr_data_o | output | 8 | Write data |
| wr_be_o | output | 8 | Write bit-enable mask |

## Verification
The bench builds the block with its defaults: a 2-stage synchronizer, read-only bytes at 0x0C/0x0D and bit-7 masking at 0x00/0x0A. With a 2-stage synchronizer, the 3-edge latency from an input edge to the write pulse can be checked to the exact cycle. With the default address choices, both masked locations and both read-only locations can be reached in each bus mode. The sequences cover an address strobe that rises again before the data phase, an address loaded with chip select high, and an address loaded and then frozen under write protect.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;

  typedef struct packed {
    logic as;
    logic ds;
    logic rw;
    logic cs_n;
    logic wp;
    logic lk_n;
  } strb_t;

  // reset image of the synchronized strobes: deselected, locked, no strobe
  localparam strb_t STRB_IDLE = '{as: 1'b0, ds: 1'b0, rw: 1'b1,
                                  cs_n: 1'b1, wp: 1'b0, lk_n: 1'b0};

  typedef enum logic {
    MODE_SEP = 1'b0,
    MODE_DS  = 1'b1
  } bus_mode_e;

endpackage

// File: rtl/mbus_sync.sv
`timescale 1ns/1ps
module mbus_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= RST_VAL;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/mbus_addr_latch.sv
`timescale 1ns/1ps
module mbus_addr_latch #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_i,
  input  logic              freeze_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vld_o
);

  logic as_q;
  logic as_rise, as_fall;

  assign as_rise = as_i & ~as_q;
  assign as_fall = ~as_i & as_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q   <= 1'b0;
      addr_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      as_q <= as_i;
      if (!freeze_i) begin
        if (as_rise) begin
          addr_o <= '0;
          vld_o  <= 1'b0;
        end else if (as_fall) begin
          addr_o <= addr_i;
          vld_o  <= 1'b1;
        end
      end
    end
  end

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && as_q && !as_i) |=> (vld_o && addr_o == $past(addr_i)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && !as_q && as_i) |=> (!vld_o && addr_o == '0));

  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> ($stable(addr_o) && $stable(vld_o)));

endmodule

// File: rtl/mbus_access_ctrl.sv
`timescale 1ns/1ps
module mbus_access_ctrl import mbus_pkg::*; #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int RO_ADDR_0 = 12,
  parameter int RO_ADDR_1 = 13,
  parameter int MSK_ADDR_0 = 0,
  parameter int MSK_ADDR_1 = 10,
  parameter int MSK_BIT   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_mode_e         mode_i,
  input  logic              ds_i,
  input  logic              rw_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              oe_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [DATA_W-1:0] wr_be_o
);

  localparam logic [ADDR_W-1:0] RO_A0  = ADDR_W'(RO_ADDR_0);
  localparam logic [ADDR_W-1:0] RO_A1  = ADDR_W'(RO_ADDR_1);
  localparam logic [ADDR_W-1:0] MSK_A0 = ADDR_W'(MSK_ADDR_0);
  localparam logic [ADDR_W-1:0] MSK_A1 = ADDR_W'(MSK_ADDR_1);

  logic ds_q, rw_q;
  logic live;
  logic rd_cond, wr_edge, wr_cond;
  logic ro_hit, msk_hit;
  logic [DATA_W-1:0] be_d;

  assign live    = sel_i & vld_i;
  assign ro_hit  = (addr_i == RO_A0) || (addr_i == RO_A1);
  assign msk_hit = (addr_i == MSK_A0) || (addr_i == MSK_A1);

  always_comb begin
    unique case (mode_i)
      MODE_DS: begin
        rd_cond = ds_i & rw_i;
        wr_edge = ds_q & ~ds_i & ~rw_i;   // trailing edge of data strobe
      end
      default: begin
        rd_cond = ~ds_i;
        wr_edge = ~rw_q & rw_i;           // trailing edge of write strobe
      end
    endcase
  end

  assign wr_cond = wr_edge & live & ~ro_hit;

  for (genvar b = 0; b < DATA_W; b++) begin : g_be
    assign be_d[b] = !(msk_hit && (b == MSK_BIT));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ds_q      <= 1'b0;
      rw_q      <= 1'b1;
      oe_o      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_be_o   <= '0;
    end else begin
      ds_q    <= ds_i;
      rw_q    <= rw_i;
      oe_o    <= rd_cond & live;
      wr_en_o <= wr_cond;
      if (wr_cond) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
        wr_be_o   <= be_d;
      end
    end
  end

  p_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  p_no_ro_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !(wr_addr_o == RO_A0 || wr_addr_o == RO_A1));

  p_mask_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && (wr_addr_o == MSK_A0 || wr_addr_o == MSK_A1)) |-> !wr_be_o[MSK_BIT]);

  p_ds_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DS && !ds_i) |=> !oe_o);

  p_rd_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SEP && ds_i) |=> !oe_o);

  p_need_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> (!oe_o && !wr_en_o));

endmodule

// File: rtl/mbus_port.sv
`timescale 1ns/1ps
module mbus_port import mbus_pkg::*; #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RO_ADDR_0   = 12,
  parameter int RO_ADDR_1   = 13,
  parameter int MSK_ADDR_0  = 0,
  parameter int MSK_ADDR_1  = 10,
  parameter int MSK_BIT     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_mode_i,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rw_i,
  input  logic              cs_ni,
  input  logic              wp_i,
  input  logic              lk_ni,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [DATA_W-1:0] wr_be_o
);

  localparam int SW = $bits(strb_t);
  localparam int VW = SW + DATA_W;
  localparam logic [VW-1:0] SYNC_RST = {STRB_IDLE, {DATA_W{1'b0}}};

  strb_t             strb_raw, strb_s;
  logic [DATA_W-1:0] ad_s;
  logic [VW-1:0]     sync_q;
  logic              sel;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_vld;

  assign strb_raw = '{as: as_i, ds: ds_i, rw: rw_i, cs_n: cs_ni, wp: wp_i, lk_n: lk_ni};

  // shared lines ride the same pipeline so data lines up with the strobe edges
  mbus_sync #(
    .W      (VW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({strb_raw, ad_i}),
    .q_o   (sync_q)
  );

  assign {strb_s, ad_s} = sync_q;
  assign sel = ~strb_s.cs_n & ~strb_s.wp & strb_s.lk_n;

  mbus_addr_latch #(.ADDR_W(ADDR_W)) u_alat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .as_i    (strb_s.as),
    .freeze_i(strb_s.wp),
    .addr_i  (ad_s[ADDR_W-1:0]),
    .addr_o  (lat_addr),
    .vld_o   (lat_vld)
  );

  mbus_access_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RO_ADDR_0 (RO_ADDR_0),
    .RO_ADDR_1 (RO_ADDR_1),
    .MSK_ADDR_0(MSK_ADDR_0),
    .MSK_ADDR_1(MSK_ADDR_1),
    .MSK_BIT   (MSK_BIT)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (bus_mode_e'(bus_mode_i)),
    .ds_i     (strb_s.ds),
    .rw_i     (strb_s.rw),
    .sel_i    (sel),
    .addr_i   (lat_addr),
    .vld_i    (lat_vld),
    .data_i   (ad_s),
    .oe_o     (ad_oe_o),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o),
    .wr_be_o  (wr_be_o)
  );

  assign ad_o      = ad_oe_o ? rd_data_i : '0;
  assign rd_req_o  = ad_oe_o;
  assign rd_addr_o = lat_addr;

  p_wp_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_s.wp |=> (!ad_oe_o && !wr_en_o));

  p_lock_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_s.lk_n |=> (!ad_oe_o && !wr_en_o));

  p_cs_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_s.cs_n |=> (!ad_oe_o && !wr_en_o));

  p_bus_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ad_oe_o |-> (ad_o == '0 && !rd_req_o));

endmodule

// File: tb/mbus_port_tb.sv
`timescale 1ns/1ps
module mbus_port_tb;

  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b1;
  logic       as_s = 1'b0, ds = 1'b0, rw = 1'b1, cs_n = 1'b1, wp = 1'b0, lk_n = 1'b1;
  logic [7:0] ad = '0;
  logic [7:0] ad_o, rd_data, wr_data, wr_be;
  logic [6:0] rd_addr, wr_addr;
  logic       ad_oe, rd_req, wr_en;

  typedef struct {
    logic [6:0] a;
    logic [7:0] d;
    logic [7:0] be;
    int         r;
  } item_t;

  item_t sb_q[$];
  item_t it;
  int    n_cmp = 0, n_bad = 0, cur_req = 14;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  assign rd_data = {1'b1, rd_addr} ^ 8'h5A;

  mbus_port #(.SYNC_STAGES(SYNC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_mode_i(mode), .as_i(as_s), .ds_i(ds),
    .rw_i(rw), .cs_ni(cs_n), .wp_i(wp), .lk_ni(lk_n), .ad_i(ad), .ad_o(ad_o),
    .ad_oe_o(ad_oe), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_be_o(wr_be)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    return {1'b1, a[6:0]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every write pulse must match the oldest expected item
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      n_cmp++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R%0d unexpected write actual %h/%h expected none", cur_req, wr_addr, wr_data);
      end else begin
        it = sb_q.pop_front();
        if (wr_addr !== it.a || wr_data !== it.d || wr_be !== it.be) begin
          n_bad++;
          $display("FAIL R%0d write actual %h/%h/%h expected %h/%h/%h",
                   it.r, wr_addr, wr_data, wr_be, it.a, it.d, it.be);
        end
      end
    end
  end

  task automatic push(input logic [7:0] a, input logic [7:0] d, input logic [7:0] be, input int r);
    item_t x;
    x.a = a[6:0]; x.d = d; x.be = be; x.r = r;
    sb_q.push_back(x);
  endtask

  task automatic latch_addr(input logic [7:0] a);
    @(negedge clk); as_s = 1'b1; ad = a;
    wt(4); as_s = 1'b0;
    wt(4);
  endtask

  task automatic m1_write(input logic [7:0] a, input logic [7:0] d, input bit expect_wr,
                          input logic [7:0] be, input int r);
    cur_req = r;
    latch_addr(a);
    rw = 1'b0; ad = d;
    wt(2); ds = 1'b1;
    wt(4);
    if (expect_wr) push(a, d, be, r);
    ds = 1'b0;
    wt(4); rw = 1'b1;
    wt(4);
  endtask

  task automatic m0_write(input logic [7:0] a, input logic [7:0] d, input bit expect_wr,
                          input logic [7:0] be, input int r);
    cur_req = r;
    latch_addr(a);
    ad = d; rw = 1'b0;
    wt(4);
    if (expect_wr) push(a, d, be, r);
    rw = 1'b1;
    wt(6);
  endtask

  task automatic m1_read(input logic [7:0] a, input bit exp_oe, input string req);
    cur_req = 4;
    latch_addr(a);
    ds = 1'b1;
    wt(5);
    chk(ad_oe == exp_oe && rd_req == exp_oe, req, ad_oe, exp_oe);
    if (exp_oe) begin
      chk(ad_o == exp_rd(a), req, ad_o, exp_rd(a));
      chk(rd_addr == a[6:0], req, rd_addr, a[6:0]);
    end
    ds = 1'b0;
    wt(5);
    chk(!ad_oe, req, ad_oe, 0);
  endtask

  task automatic m0_read(input logic [7:0] a, input string req);
    cur_req = 6;
    latch_addr(a);
    chk(!ad_oe, "R1 read strobe idle high gives no drive", ad_oe, 0);
    ds = 1'b0;
    wt(5);
    chk(ad_oe && ad_o == exp_rd(a), req, {ad_oe, ad_o}, {1'b1, exp_rd(a)});
    ds = 1'b1;
    wt(5);
    chk(!ad_oe, req, ad_oe, 0);
  endtask

  initial begin
    wt(3);
    // R14 reset state
    chk(!ad_oe && !rd_req && !wr_en, "R14 reset outputs", {ad_oe, rd_req, wr_en}, 0);
    rst_n = 1'b1;
    wt(5);
    cs_n = 1'b0;

    // mode 1: strobe plus read/write level (R1)
    m1_write(8'h05, 8'h3C, 1, 8'hFF, 5);        // R5
    m1_write(8'h91, 8'hC3, 1, 8'hFF, 2);        // R2: bit 7 dropped -> 0x11
    m1_read(8'h05, 1, "R4 mode1 read drive");
    m1_read(8'hA3, 1, "R2 address bit7 ignored");
    m1_write(8'h00, 8'hFF, 1, 8'h7F, 12);       // R12
    m1_write(8'h0A, 8'hAA, 1, 8'h7F, 12);       // R12
    m1_write(8'h0B, 8'h81, 1, 8'hFF, 12);       // R12 unmasked
    m1_write(8'h0C, 8'h55, 0, 8'hFF, 11);       // R11
    m1_write(8'h0D, 8'h66, 0, 8'hFF, 11);       // R11

    // R3: address strobe rises again before the data phase
    cur_req = 3;
    latch_addr(8'h07);
    as_s = 1'b1;
    wt(6);
    ds = 1'b1;
    wt(5);
    chk(!ad_oe, "R3 no read after address cleared", ad_oe, 0);
    rw = 1'b0; ds = 1'b0;
    wt(2); ds = 1'b1; wt(4); ds = 1'b0; wt(4); rw = 1'b1;
    as_s = 1'b0;
    wt(6);

    // R8: deselected
    cs_n = 1'b1;
    m1_write(8'h06, 8'h12, 0, 8'hFF, 8);
    cur_req = 8;
    latch_addr(8'h21);
    ds = 1'b1; wt(5);
    chk(!ad_oe, "R8 no drive while deselected", ad_oe, 0);
    ds = 1'b0; wt(3);
    cs_n = 1'b0; wt(4);
    ds = 1'b1; wt(5);
    chk(ad_oe && rd_addr == 7'h21, "R8 address latched while deselected", {ad_oe, rd_addr}, {1'b1, 7'h21});
    ds = 1'b0; wt(5);

    // R9: write protect freezes the address and blocks access
    cur_req = 9;
    latch_addr(8'h31);
    wp = 1'b1; wt(4);
    latch_addr(8'h32);
    ds = 1'b1; wt(5);
    chk(!ad_oe, "R9 no drive under protect", ad_oe, 0);
    ds = 1'b0; wt(2);
    rw = 1'b0; ds = 1'b1; wt(4); ds = 1'b0; wt(4); rw = 1'b1;
    wp = 1'b0; wt(5);
    ds = 1'b1; wt(5);
    chk(ad_oe && rd_addr == 7'h31, "R9 address unchanged by protected strobe", {ad_oe, rd_addr}, {1'b1, 7'h31});
    ds = 1'b0; wt(5);

    // R10: lockout
    lk_n = 1'b0; wt(4);
    m1_write(8'h08, 8'h44, 0, 8'hFF, 10);
    m1_read(8'h08, 0, "R10 no drive under lockout");
    lk_n = 1'b1; wt(4);

    // switch to separate strobes (R1)
    cs_n = 1'b1; mode = 1'b0; ds = 1'b1; rw = 1'b1;
    wt(8);
    cs_n = 1'b0; wt(4);
    m0_write(8'h15, 8'hA5, 1, 8'hFF, 7);        // R7
    m0_write(8'h00, 8'h80, 1, 8'h7F, 12);       // R12 in mode 0
    m0_write(8'h0C, 8'h01, 0, 8'hFF, 11);       // R11 in mode 0
    m0_read(8'h15, "R6 mode0 read drive");

    // R13: exact latency from write-strobe trailing edge to the pulse
    cur_req = 13;
    latch_addr(8'h2E);
    ad = 8'h69; rw = 1'b0;
    wt(4);
    push(8'h2E, 8'h69, 8'hFF, 13);
    rw = 1'b1;
    wt(LAT - 1);
    chk(!wr_en, "R13 pulse not early", wr_en, 0);
    wt(1);
    chk(wr_en, "R13 pulse at sync+1 edges", wr_en, 1);
    wt(6);

    // every expected write must have been seen
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_cmp++; n_bad++;
      $display("FAIL R%0d missing write actual none expected %h/%h", it.r, it.a, it.d);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R14 watchdog actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule